// File: doc/BRIEF.md
# Frame-Axis Coefficient Transposer

This block sits between a two-dimensional transform stage and a final one-dimensional transform that runs along the frame axis of a cube of N frames. Its input is the stream of N two-dimensional coefficient matrices, each N by N, for one cube. Each cycle brings one matrix row as an N-word vector, with all rows of matrix 0 first, then all rows of matrix 1, and so on. Its output is the same cube reordered. Each output vector gathers the coefficient at one (row, column) position from every matrix, so the frame-axis transform can consume one whole vector per cycle.

Each matrix has its own lane. Every lane except the last parks its rows in a staging bank, which delays it relative to the later matrices. Once the last matrix begins, all lanes move row r into a line bank in the same cycle. A single row select, shared by every lane, steps every N output cycles and reloads a per-lane word shift chain. The chain then emits one column per cycle. The block uses no RAM, only registers and multiplexers. An output position tag (row, column) travels with each valid vector. N must be a power of two.

Top module: `volume_transposer`

## Requirements
- R1: While the synchronous active-high reset is asserted, and right after it is released, out_valid is 0 and out_row and out_col are both 0.
- R2: A cube is N matrices sent in matrix-major order, with each matrix's rows in row order. Input word c (bits c*W+:W of in_vec) is column c of the current row. Output word m (bits m*W+:W of out_vec) equals the coefficient of matrix m at position (out_row, out_col).
- R3: While out_valid stays high, out_col rises by one each cycle from 0 to N-1, and out_row holds within a row.
- R4: If the first vector of a cube is sampled on clock edge E, out_valid first rises after edge E+N*N-N+1, showing position (0,0).
- R5: A cube arrives as N*N vectors with in_valid high on consecutive cycles. For each cube, out_valid stays high for exactly N*N consecutive cycles. It goes low after the last vector unless another cube follows at once.
- R6: out_row advances by one each time out_col wraps from N-1 to 0, so the shared row select steps every N outputs. After position (N-1,N-1) the position tag returns to (0,0).
- R7: If a cube starts on the cycle right after the previous cube's last input, its first output follows the previous cube's last output with no idle cycle. Its inputs, which arrive while the previous cube is still draining, do not alter the previous cube's outputs.
- R8: Cycles with in_valid low between cubes are ignored whatever in_vec holds. They produce no output and do not shift the timing or the data of the next cube.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input row vector valid |
| in_vec | input | N*W | One matrix row, word c = column c |
| out_valid | output | 1 | Output vector valid |
| out_vec | output | N*W | Word m = matrix m coefficient at the tagged position |
| out_row | output | log2(N) | Row of the current output position |
| out_col | output | log2(N) | Column of the current output position |

## Verification
When cubes arrive back to back, two things fall in the same cycle. The last output of one cube shifts out on the same edge that reloads row 0 of the next cube into every lane. Meanwhile the next cube's rows are being written into the staging banks while the earlier cube is still being read out. The bench provokes both by sending several cubes with no idle cycle between them. It judges the result by three checks. The next cube's first vector must appear on exactly the predicted cycle with no gap in out_valid. Every word of every vector must match the coefficient taken from the stimulus. The position tags must keep stepping without a break.

// File: rtl/vt_pkg.sv
package vt_pkg;

    // Command to a lane's output word chain: load a whole row or shift one word.
    typedef struct packed {
        logic load;
        logic shift;
    } head_cmd_t;

endpackage

// File: rtl/vt_in_ctrl.sv
module vt_in_ctrl #(
    parameter int N    = 8,
    parameter int LOGN = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic [N-1:0]    pend_we,
    output logic [LOGN-1:0] wr_row,
    output logic            xfer_en,
    output logic            vol_start
);
    localparam int CW = 2 * LOGN;
    localparam logic [LOGN-1:0] MAT_LAST = LOGN'(N - 1);

    logic [CW-1:0]   in_cnt;
    logic [LOGN-1:0] mat;

    always_ff @(posedge clk) begin
        if (rst)           in_cnt <= '0;
        else if (in_valid) in_cnt <= in_cnt + 1'b1;
    end

    assign mat       = in_cnt[CW-1:LOGN];
    assign wr_row    = in_cnt[LOGN-1:0];
    assign xfer_en   = in_valid && (mat == MAT_LAST);
    assign vol_start = xfer_en && (wr_row == '0);

    always_comb begin
        for (int m = 0; m < N; m++) begin
            pend_we[m] = in_valid && (mat == LOGN'(m)) && (m != N - 1);
        end
    end

    // R5
    vol_contig_chk: assert property (@(posedge clk) disable iff (rst)
        (in_cnt != '0) |-> in_valid);

endmodule

// File: rtl/vt_lane.sv
module vt_lane #(
    parameter int N        = 8,
    parameter int W        = 16,
    parameter bit HAS_PEND = 1'b1,
    parameter int LOGN     = $clog2(N)
) (
    input  logic              clk,
    input  logic [N*W-1:0]    in_row,
    input  logic              pend_we,
    input  logic [LOGN-1:0]   wr_row,
    input  logic              xfer_en,
    input  vt_pkg::head_cmd_t cmd,
    input  logic [LOGN-1:0]   sel,
    output logic [W-1:0]      word_out
);
    logic [N*W-1:0]        main_q [N];
    logic [N*W-1:0]        xfer_src;
    logic [N-1:0][W-1:0]   head_q;

    generate
        if (HAS_PEND) begin : g_stage
            logic [N*W-1:0] pend_q [N];
            always_ff @(posedge clk) begin
                if (pend_we) pend_q[wr_row] <= in_row;
            end
            assign xfer_src = pend_q[wr_row];
        end else begin : g_direct
            logic pend_we_unused;
            assign pend_we_unused = pend_we;
            assign xfer_src       = in_row;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (xfer_en) main_q[wr_row] <= xfer_src;
    end

    always_ff @(posedge clk) begin
        if (cmd.load)       head_q <= main_q[sel];
        else if (cmd.shift) head_q <= {{W{1'b0}}, head_q[N-1:1]};
    end

    assign word_out = head_q[0];

endmodule

// File: rtl/vt_rd_seq.sv
module vt_rd_seq #(
    parameter int N    = 8,
    parameter int LOGN = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vol_start,
    output logic              out_valid,
    output logic [LOGN-1:0]   row,
    output logic [LOGN-1:0]   col,
    output vt_pkg::head_cmd_t cmd,
    output logic [LOGN-1:0]   sel
);
    localparam logic [LOGN-1:0] LAST = LOGN'(N - 1);

    logic rd_go, vld, at_end, begin_vol, row_done;
    logic [LOGN-1:0] row_q, col_q;

    assign at_end    = (row_q == LAST) && (col_q == LAST);
    assign begin_vol = rd_go && (!vld || at_end);
    assign row_done  = vld && !at_end && (col_q == LAST);

    always_comb begin
        cmd.load  = begin_vol || row_done;
        cmd.shift = vld && !(begin_vol || row_done);
        sel       = begin_vol ? '0 : row_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_go <= 1'b0;
            vld   <= 1'b0;
            row_q <= '0;
            col_q <= '0;
        end else begin
            rd_go <= vol_start;
            if (begin_vol) begin
                vld   <= 1'b1;
                row_q <= '0;
                col_q <= '0;
            end else if (vld) begin
                if (at_end) begin
                    vld   <= 1'b0;
                    row_q <= '0;
                    col_q <= '0;
                end else if (col_q == LAST) begin
                    col_q <= '0;
                    row_q <= row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
        end
    end

    assign out_valid = vld;
    assign row       = row_q;
    assign col       = col_q;

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && col_q != LAST) |=> (vld && col_q == $past(col_q) + 1'b1 && row_q == $past(row_q)));

    // R6
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && col_q == LAST && row_q != LAST) |=> (vld && col_q == '0 && row_q == $past(row_q) + 1'b1));

    // R5
    rd_go_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rd_go |-> (!vld || at_end));

    // R8
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && at_end && !rd_go) |=> !vld);

endmodule

// File: rtl/volume_transposer.sv
module volume_transposer #(
    parameter int N    = 8,
    parameter int W    = 16,
    parameter int LOGN = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [N*W-1:0]  in_vec,
    output logic            out_valid,
    output logic [N*W-1:0]  out_vec,
    output logic [LOGN-1:0] out_row,
    output logic [LOGN-1:0] out_col
);
    logic [N-1:0]      pend_we;
    logic [LOGN-1:0]   wr_row;
    logic              xfer_en;
    logic              vol_start;
    vt_pkg::head_cmd_t cmd;
    logic [LOGN-1:0]   sel;

    vt_in_ctrl #(.N(N), .LOGN(LOGN)) u_in (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .pend_we   (pend_we),
        .wr_row    (wr_row),
        .xfer_en   (xfer_en),
        .vol_start (vol_start)
    );

    vt_rd_seq #(.N(N), .LOGN(LOGN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .vol_start (vol_start),
        .out_valid (out_valid),
        .row       (out_row),
        .col       (out_col),
        .cmd       (cmd),
        .sel       (sel)
    );

    generate
        for (genvar g = 0; g < N; g++) begin : g_lane
            vt_lane #(.N(N), .W(W), .HAS_PEND(g != N - 1), .LOGN(LOGN)) u_lane (
                .clk      (clk),
                .in_row   (in_vec),
                .pend_we  (pend_we[g]),
                .wr_row   (wr_row),
                .xfer_en  (xfer_en),
                .cmd      (cmd),
                .sel      (sel),
                .word_out (out_vec[g*W +: W])
            );
        end
    endgenerate

    // R4
    first_out_chk: assert property (@(posedge clk) disable iff (rst)
        vol_start |=> ##1 (out_valid && out_row == '0 && out_col == '0));

endmodule

// File: tb/volume_transposer_tb.sv
module volume_transposer_tb;
    localparam int N    = 8;
    localparam int W    = 16;
    localparam int LOGN = 3;
    localparam int VOL  = N * N;
    localparam int LAT  = N * N - N + 2;

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic [N*W-1:0] in_vec;
    logic out_valid;
    logic [N*W-1:0] out_vec;
    logic [LOGN-1:0] out_row, out_col;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    logic [W-1:0] vol [4][N][N][N];
    int start_cyc [4];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    volume_transposer #(.N(N), .W(W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
        .out_valid(out_valid), .out_vec(out_vec), .out_row(out_row), .out_col(out_col)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_vec = '0;
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", int'(out_valid), 0);
        chk("R1", "row in reset", int'(out_row), 0);
        chk("R1", "col in reset", int'(out_col), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", int'(out_valid), 0);
        chk("R1", "tag after reset", int'({out_row, out_col}), 0);
    endtask

    // mode 0 random, 1 position-coded, 2 alternating extremes
    task automatic run(input int nvol, input int gap, input int mode);
        for (int vi = 0; vi < nvol; vi++)
            for (int m = 0; m < N; m++)
                for (int u = 0; u < N; u++)
                    for (int v = 0; v < N; v++)
                        case (mode)
                            0: vol[vi][m][u][v] = W'($urandom);
                            1: vol[vi][m][u][v] = W'((vi << 12) | (m << 8) | (u << 4) | v);
                            default: vol[vi][m][u][v] = ((m + u + v + vi) % 2) ? 16'hFFFF : 16'h0000;
                        endcase
        fork
            begin : drive
                for (int vi = 0; vi < nvol; vi++) begin
                    if (vi > 0) begin
                        for (int g = 0; g < gap; g++) begin
                            @(negedge clk);
                            in_valid = 1'b0;
                            in_vec = {$urandom, $urandom, $urandom, $urandom};
                        end
                    end
                    for (int t = 0; t < VOL; t++) begin
                        @(negedge clk);
                        in_valid = 1'b1;
                        for (int c = 0; c < N; c++) in_vec[c*W +: W] = vol[vi][t / N][t % N][c];
                        if (t == 0) start_cyc[vi] = cyc;
                    end
                end
                @(negedge clk);
                in_valid = 1'b0;
                in_vec = {$urandom, $urandom, $urandom, $urandom};
            end
            begin : collect
                @(negedge clk);
                for (int vi = 0; vi < nvol; vi++) begin
                    int guard = 0;
                    while (!out_valid && guard < 1000) begin
                        @(negedge clk);
                        guard++;
                    end
                    chk((vi > 0 && gap == 0) ? "R7" : (vi > 0 ? "R8" : "R4"),
                        "first output cycle", cyc, start_cyc[vi] + LAT);
                    for (int k = 0; k < VOL; k++) begin
                        chk("R5", "valid during cube", int'(out_valid), 1);
                        chk("R6", "out_row", int'(out_row), k / N);
                        chk("R3", "out_col", int'(out_col), k % N);
                        for (int m = 0; m < N; m++)
                            chk(gap == 0 && vi > 0 ? "R7" : "R2", "word",
                                int'(out_vec[m*W +: W]), int'(vol[vi][m][k / N][k % N]));
                        @(negedge clk);
                    end
                end
                chk("R5", "valid after last cube", int'(out_valid), 0);
                chk("R6", "tag wrap", int'({out_row, out_col}), 0);
            end
        join
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        run(1, 0, 1);   // single cube, coded values
        run(3, 0, 0);   // back-to-back cubes
        run(2, 5, 0);   // short idle gap with junk on in_vec
        run(2, 70, 2);  // long idle gap, extreme values
        run(2, 0, 1);   // back-to-back, coded values
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule